// File: doc/BRIEF.md
# Floating-Point Add Exception Flag Unit

This block examines the sum of two single-precision binary floating-point operands and reports which IEEE-754 exceptions that sum would raise. The sum itself is never produced. The only result is a small flag vector, with a write-enable that tells the surrounding datapath whether to store it.

Operands that are subnormal are treated as zero before the addition, and a separate flag records that this happened. A sum whose exact magnitude falls below the smallest normal number is flushed to zero, and another flag reports that. The rounding direction comes from a 2-bit mode input and affects the inexact and overflow outcomes. A guard word qualifies the write: only its least significant bit matters.

The unit is fully pipelined. It takes one operation per clock, with a valid bit that travels alongside the data. It never touches any shared exception status; it only drives its own outputs.

Top module: `fadd_flag_unit`

## Requirements
- R1: The flag word places flushed-result at bit 6, flushed-input at bit 5, invalid at bit 4, overflow at bit 3, underflow at bit 2, inexact at bit 1 and divide-by-zero at bit 0. Bit 0 is always 0, and every bit above 6 is always 0.
- R2: For finite operands under round-to-nearest-even, inexact is set exactly when the rounded sum differs from the exact sum. For example, 0x7f7fffff plus 0x3f800000 gives 0x02.
- R3: When the rounded sum exceeds the largest finite magnitude, overflow and inexact are both set. For example, 0x7f7fffff plus 0x7f7fffff gives 0x0a.
- R4: The rounding mode is encoded as 00 nearest-even, 01 toward zero, 10 toward +infinity and 11 toward -infinity. The mode decides rounding, and therefore overflow. For example, 0x7f7fffff plus 0x3f800000 gives 0x0a under mode 10 and 0x02 under modes 00, 01 and 11.
- R5: A subnormal operand (exponent field 0, fraction nonzero) is replaced by zero before the addition and sets flushed-input. For example, 0x40400000 plus 0x00400000 gives 0x20.
- R6: A nonzero exact sum whose magnitude is below 2^-126 sets flushed-result, underflow and inexact. For example, 0x00a00000 plus 0x80800000 gives 0x46.
- R7: A NaN operand, or infinities of opposite sign, sets invalid. An exact sum, infinity plus a finite value, and infinities of the same sign raise no flag.
- R8: out_wr_en is 1 only for a valid operation whose guard bit 0 was 1. The guard bits above bit 0 have no effect, and the flags are reported whatever the guard value.
- R9: The result for an operation issued in cycle n appears in cycle n+3. One operation is accepted every cycle, and out_valid repeats in_valid three cycles later.
- R10: Reset clears every valid stage, so out_valid and out_wr_en are 0 during reset and for three cycles after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| in_guard | input | GUARD_W | Guard word; only bit 0 qualifies the write |
| in_a | input | 1+EXP_W+FRAC_W | First operand |
| in_b | input | 1+EXP_W+FRAC_W | Second operand |
| in_rmode | input | 2 | Rounding mode (00 nearest-even, 01 to zero, 10 to +inf, 11 to -inf) |
| out_valid | output | 1 | Flags valid, three cycles after issue |
| out_wr_en | output | 1 | Store the flags (valid and guard bit 0) |
| out_flags | output | FLAG_W | Exception flag word |

## Verification
Each stage holds a slice of the operation: the aligned mantissas, then the normalized exponent and mantissa, then the flags. A wrong stage value therefore shows up as wrong flag bits three cycles after issue.

A sticky bit lost during alignment clears inexact. A leading-zero count that is off by one moves the exponent, which either triggers a false flush or hides a real one. A rounding increment that fails to carry hides an overflow under the directed modes. Valid or guard bits that drift between stages show up on out_valid or out_wr_en in the same cycle as the flags they belong to.

// File: rtl/faf_pkg.sv
package faf_pkg;

   // Rounding direction (R4)
   typedef enum logic [1:0] {
      RM_NEAR_EVEN = 2'b00,
      RM_TO_ZERO   = 2'b01,
      RM_TO_POS    = 2'b10,
      RM_TO_NEG    = 2'b11
   } rmode_e;

   // Flag bit positions (R1)
   localparam int FLAG_N        = 7;
   localparam int FB_DIVZERO    = 0;
   localparam int FB_INEXACT    = 1;
   localparam int FB_UNDERFLOW  = 2;
   localparam int FB_OVERFLOW   = 3;
   localparam int FB_INVALID    = 4;
   localparam int FB_FLUSH_IN   = 5;
   localparam int FB_FLUSH_OUT  = 6;

endpackage

// File: rtl/faf_align.sv
// Stage 1: decode both operands, flush subnormals, order by magnitude,
// align the smaller mantissa with guard/round/sticky bits.
module faf_align #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic [EXP_W+FRAC_W:0] a,
   input  logic [EXP_W+FRAC_W:0] b,
   output logic                  spec,
   output logic                  spec_inv,
   output logic                  flush_in,
   output logic                  sign_big,
   output logic                  eff_sub,
   output logic [EXP_W-1:0]      exp_big,
   output logic [FRAC_W+3:0]     man_big,
   output logic [FRAC_W+3:0]     man_small
);
   localparam int MANT_W = FRAC_W + 1;
   localparam int AW     = MANT_W + 3;
   localparam int SGN_B  = EXP_W + FRAC_W;

   logic [EXP_W+FRAC_W:0] op [2];
   logic [1:0]            is_nan, is_inf, is_den, sgn;
   logic [EXP_W-1:0]      ex [2];
   logic [MANT_W-1:0]     mn [2];
   logic                  big, sm;
   logic [EXP_W-1:0]      diff;
   logic [2*AW-1:0]       wide;

   assign op[0] = a;
   assign op[1] = b;

   for (genvar i = 0; i < 2; i++) begin : g_dec
      logic [EXP_W-1:0]  e;
      logic [FRAC_W-1:0] f;
      assign e         = op[i][FRAC_W +: EXP_W];
      assign f         = op[i][FRAC_W-1:0];
      assign is_nan[i] = (e == '1) && (f != '0);
      assign is_inf[i] = (e == '1) && (f == '0);
      assign is_den[i] = (e == '0) && (f != '0);
      assign sgn[i]    = op[i][SGN_B];
      assign ex[i]     = e;
      assign mn[i]     = (e == '0) ? '0 : {1'b1, f};
   end

   assign spec     = (|is_nan) || (|is_inf);
   assign spec_inv = (|is_nan) || (is_inf[0] && is_inf[1] && (sgn[0] ^ sgn[1]));
   assign flush_in = |is_den;

   assign big      = ({ex[1], mn[1]} > {ex[0], mn[0]});
   assign sm       = ~big;
   assign eff_sub  = sgn[0] ^ sgn[1];
   assign sign_big = sgn[big];
   assign exp_big  = ex[big];
   assign diff     = ex[big] - ex[sm];
   assign man_big  = {mn[big], 3'b000};

   assign wide = {mn[sm], 3'b000, {AW{1'b0}}} >> diff;

   always_comb begin
      if (int'(diff) >= AW)
         man_small = {{(AW-1){1'b0}}, |mn[sm]};
      else
         man_small = wide[2*AW-1:AW] | {{(AW-1){1'b0}}, |wide[AW-1:0]};
   end

endmodule

// File: rtl/faf_normalize.sv
// Stage 2: effective add or subtract, then normalize so the leading one
// sits at the top bit, adjusting the exponent.
module faf_normalize #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic                            eff_sub,
   input  logic [EXP_W-1:0]                exp_big,
   input  logic [FRAC_W+3:0]               man_big,
   input  logic [FRAC_W+3:0]               man_small,
   output logic                            zero,
   output logic                            tiny,
   output logic signed [EXP_W+1:0]         nexp,
   output logic [FRAC_W+3:0]               nman
);
   localparam int AW   = FRAC_W + 4;
   localparam int SE_W = EXP_W + 2;
   localparam int LZW  = $clog2(AW + 1);

   logic [AW:0]    sum;
   logic [LZW-1:0] lz;

   assign sum  = eff_sub ? ({1'b0, man_big} - {1'b0, man_small})
                         : ({1'b0, man_big} + {1'b0, man_small});
   assign zero = (sum == '0);

   always_comb begin
      lz = LZW'(AW);
      for (int i = 0; i < AW; i++)
         if (sum[i]) lz = LZW'(AW - 1 - i);
   end

   always_comb begin
      if (sum[AW]) begin
         nman = sum[AW:1] | {{(AW-1){1'b0}}, sum[0]};
         nexp = SE_W'(exp_big) + SE_W'(1);
      end else begin
         nman = sum[AW-1:0] << lz;
         nexp = SE_W'(exp_big) - SE_W'(lz);
      end
   end

   assign tiny = !zero && (nexp <= 0);

endmodule

// File: rtl/faf_round.sv
// Stage 3: apply the rounding direction and assemble the flag bits.
module faf_round
   import faf_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic [1:0]               rmode,
   input  logic                     sign,
   input  logic signed [EXP_W+1:0]  nexp,
   input  logic [FRAC_W+3:0]        nman,
   input  logic                     zero,
   input  logic                     tiny,
   input  logic                     spec,
   input  logic                     spec_inv,
   input  logic                     flush_in,
   output logic [FLAG_N-1:0]        flags
);
   localparam int MANT_W = FRAC_W + 1;
   localparam int AW     = FRAC_W + 4;
   localparam int SE_W   = EXP_W + 2;
   localparam logic signed [SE_W-1:0] EMAX_S = SE_W'((1 << EXP_W) - 1);

   rmode_e              rm;
   logic                inexact, up, ovf;
   logic [MANT_W:0]     rounded;
   logic signed [SE_W-1:0] rexp;

   assign rm      = rmode_e'(rmode);
   assign inexact = |nman[2:0];

   always_comb begin
      unique case (rm)
         RM_NEAR_EVEN: up = nman[2] && (nman[1] || nman[0] || nman[3]);
         RM_TO_ZERO:   up = 1'b0;
         RM_TO_POS:    up = inexact && !sign;
         RM_TO_NEG:    up = inexact && sign;
         default:      up = 1'b0;
      endcase
   end

   assign rounded = {1'b0, nman[AW-1:3]} + (MANT_W+1)'(up);
   assign rexp    = nexp + SE_W'(rounded[MANT_W]);
   assign ovf     = (rexp >= EMAX_S);

   always_comb begin
      flags              = '0;
      flags[FB_FLUSH_IN] = flush_in;
      if (spec) begin
         flags[FB_INVALID] = spec_inv;
      end else if (zero) begin
         flags[FB_INEXACT] = 1'b0;
      end else if (tiny) begin
         flags[FB_FLUSH_OUT] = 1'b1;
         flags[FB_UNDERFLOW] = 1'b1;
         flags[FB_INEXACT]   = 1'b1;
      end else begin
         flags[FB_OVERFLOW] = ovf;
         flags[FB_INEXACT]  = inexact || ovf;
      end
   end

endmodule

// File: rtl/fadd_flag_unit.sv
// Three-stage pipeline reporting the exception flags of a floating add.
module fadd_flag_unit
   import faf_pkg::*;
#(
   parameter int EXP_W   = 8,
   parameter int FRAC_W  = 23,
   parameter int FLAG_W  = 32,
   parameter int GUARD_W = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic [GUARD_W-1:0]       in_guard,
   input  logic [EXP_W+FRAC_W:0]    in_a,
   input  logic [EXP_W+FRAC_W:0]    in_b,
   input  logic [1:0]               in_rmode,
   output logic                     out_valid,
   output logic                     out_wr_en,
   output logic [FLAG_W-1:0]        out_flags
);
   localparam int AW   = FRAC_W + 4;
   localparam int SE_W = EXP_W + 2;

   // Elaboration-time parameter checks
   if (FLAG_W < FLAG_N) begin : g_bad_flag_w
      $error("FLAG_W must hold all %0d flag bits", FLAG_N);
   end
   if (FRAC_W < 3 || EXP_W < 3) begin : g_bad_fmt
      $error("operand format too narrow");
   end
   if (GUARD_W < 1) begin : g_bad_guard
      $error("GUARD_W must be at least 1");
   end

   if (GUARD_W > 1) begin : g_guard_hi
      logic unused_guard_hi;
      assign unused_guard_hi = ^in_guard[GUARD_W-1:1];
   end

   // Stage 1 combinational + registers
   logic              c1_spec, c1_inv, c1_fin, c1_sgn, c1_sub;
   logic [EXP_W-1:0]  c1_exp;
   logic [AW-1:0]     c1_mbig, c1_msm;

   faf_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
      .a(in_a), .b(in_b),
      .spec(c1_spec), .spec_inv(c1_inv), .flush_in(c1_fin),
      .sign_big(c1_sgn), .eff_sub(c1_sub), .exp_big(c1_exp),
      .man_big(c1_mbig), .man_small(c1_msm)
   );

   logic              v1, g1, spec1, inv1, fin1, sgn1, sub1;
   logic [1:0]        rm1;
   logic [EXP_W-1:0]  exp1;
   logic [AW-1:0]     mbig1, msm1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v1 <= 1'b0;
      else        v1 <= in_valid;
   end

   always_ff @(posedge clk) begin
      g1    <= in_guard[0];
      rm1   <= in_rmode;
      spec1 <= c1_spec;
      inv1  <= c1_inv;
      fin1  <= c1_fin;
      sgn1  <= c1_sgn;
      sub1  <= c1_sub;
      exp1  <= c1_exp;
      mbig1 <= c1_mbig;
      msm1  <= c1_msm;
   end

   // Stage 2
   logic                   c2_zero, c2_tiny;
   logic signed [SE_W-1:0] c2_nexp;
   logic [AW-1:0]          c2_nman;

   faf_normalize #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_norm (
      .eff_sub(sub1), .exp_big(exp1), .man_big(mbig1), .man_small(msm1),
      .zero(c2_zero), .tiny(c2_tiny), .nexp(c2_nexp), .nman(c2_nman)
   );

   logic                   v2, g2, spec2, inv2, fin2, sgn2, zero2, tiny2;
   logic [1:0]             rm2;
   logic signed [SE_W-1:0] nexp2;
   logic [AW-1:0]          nman2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v2 <= 1'b0;
      else        v2 <= v1;
   end

   always_ff @(posedge clk) begin
      g2    <= g1;
      rm2   <= rm1;
      spec2 <= spec1;
      inv2  <= inv1;
      fin2  <= fin1;
      sgn2  <= sgn1;
      zero2 <= c2_zero;
      tiny2 <= c2_tiny;
      nexp2 <= c2_nexp;
      nman2 <= c2_nman;
   end

   // Stage 3
   logic [FLAG_N-1:0] c3_flags;
   logic [FLAG_W-1:0] c3_wide;

   faf_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_round (
      .rmode(rm2), .sign(sgn2), .nexp(nexp2), .nman(nman2),
      .zero(zero2), .tiny(tiny2), .spec(spec2), .spec_inv(inv2),
      .flush_in(fin2), .flags(c3_flags)
   );

   if (FLAG_W > FLAG_N) begin : g_pad
      assign c3_wide = {{(FLAG_W-FLAG_N){1'b0}}, c3_flags};
   end else begin : g_exact
      assign c3_wide = c3_flags;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_wr_en <= 1'b0;
      end else begin
         out_valid <= v2;
         out_wr_en <= v2 && g2;
      end
   end

   always_ff @(posedge clk) out_flags <= c3_wide;

endmodule

// File: rtl/faf_checker.sv
module faf_checker #(
   parameter int FLAG_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_guard0,
   input logic              out_valid,
   input logic              out_wr_en,
   input logic [FLAG_W-1:0] out_flags
);
   logic [1:0] age;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          age <= '0;
      else if (age != 2'd3) age <= age + 2'd1;
   end

   assert_divzero_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !out_flags[0]);

   if (FLAG_W > 7) begin : g_hi
      assert_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> (out_flags[FLAG_W-1:7] == '0));
   end

   assert_ovf_inexact_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_flags[3]) |-> out_flags[1]);

   assert_flush_out_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_flags[6]) |-> (out_flags[2] && out_flags[1]));

   assert_invalid_alone_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_flags[4]) |-> (out_flags[6:1] & 6'b001111) == 6'b001000);

   assert_wr_needs_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_wr_en |-> out_valid);

   assert_valid_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd3) |-> (out_valid == $past(in_valid, 3)));

   assert_wr_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd3) |-> (out_wr_en == $past(in_valid && in_guard0, 3)));

   assert_reset_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (age != 2'd3) |-> (!out_valid && !out_wr_en));

endmodule

bind fadd_flag_unit faf_checker #(.FLAG_W(FLAG_W)) i_faf_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_guard0(in_guard[0]),
   .out_valid(out_valid), .out_wr_en(out_wr_en), .out_flags(out_flags)
);

// File: tb/test_fadd_flag_unit.sv
`timescale 1ns/1ps
module test_fadd_flag_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_guard = '0;
   logic [31:0] in_a = '0;
   logic [31:0] in_b = '0;
   logic [1:0]  in_rmode = '0;
   logic        out_valid;
   logic        out_wr_en;
   logic [31:0] out_flags;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [9:0] exp_q [$];
   string      tag_q [$];

   always #2.5 clk = ~clk;

   fadd_flag_unit i_fadd_flag_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_guard(in_guard),
      .in_a(in_a), .in_b(in_b), .in_rmode(in_rmode),
      .out_valid(out_valid), .out_wr_en(out_wr_en), .out_flags(out_flags)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
      end
   endtask

   // Behavioural reference: exact sum on a wide integer grid (unit 2^-149)
   function automatic logic [7:0] ref_flags(input logic [31:0] a, input logic [31:0] b,
                                            input logic [1:0] rm);
      logic [7:0]   ea, eb;
      logic [22:0]  fa, fb;
      bit           nan_a, nan_b, inf_a, inf_b, den_a, den_b, sgn, inexact, up;
      logic [299:0] na, nb, mag, kept, rem, half;
      logic [7:0]   r;
      int           p, sh, e;
      ea = a[30:23]; fa = a[22:0]; eb = b[30:23]; fb = b[22:0];
      nan_a = (ea == 8'hff) && (fa != 0); nan_b = (eb == 8'hff) && (fb != 0);
      inf_a = (ea == 8'hff) && (fa == 0); inf_b = (eb == 8'hff) && (fb == 0);
      den_a = (ea == 0) && (fa != 0);     den_b = (eb == 0) && (fb != 0);
      r = 8'h00;
      if (den_a || den_b) r[5] = 1'b1;
      if (nan_a || nan_b) begin r[4] = 1'b1; return r; end
      if (inf_a && inf_b && (a[31] != b[31])) begin r[4] = 1'b1; return r; end
      if (inf_a || inf_b) return r;
      na = (ea == 0) ? '0 : (300'({1'b1, fa}) << (ea - 1));
      nb = (eb == 0) ? '0 : (300'({1'b1, fb}) << (eb - 1));
      if (a[31] == b[31]) begin mag = na + nb; sgn = a[31]; end
      else if (na >= nb)  begin mag = na - nb; sgn = a[31]; end
      else                begin mag = nb - na; sgn = b[31]; end
      if (mag == 0) return r;
      if (mag < (300'(1) << 23)) begin r[6] = 1'b1; r[2] = 1'b1; r[1] = 1'b1; return r; end
      p = -1;
      for (int i = 299; i >= 0; i--) if (p < 0 && mag[i]) p = i;
      sh = p - 23;
      kept = mag >> sh;
      rem = mag & ((300'(1) << sh) - 1);
      inexact = (rem != 0);
      half = (sh > 0) ? (300'(1) << (sh - 1)) : '0;
      case (rm)
         2'b00: up = (sh > 0) && ((rem > half) || ((rem == half) && kept[0]));
         2'b01: up = 1'b0;
         2'b10: up = inexact && !sgn;
         default: up = inexact && sgn;
      endcase
      kept = kept + 300'(up);
      e = p - 22;
      if (kept[24]) e = e + 1;
      if (e >= 255) begin r[3] = 1'b1; r[1] = 1'b1; end
      else if (inexact) r[1] = 1'b1;
      return r;
   endfunction

   task automatic compare_head();
      logic [9:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(out_valid === e[9], t, "out_valid (R9)", 32'(out_valid), 32'(e[9]));
      check(out_wr_en === e[8], t, "out_wr_en (R8)", 32'(out_wr_en), 32'(e[8]));
      if (e[9])
         check(out_flags === {24'h0, e[7:0]}, t, "out_flags", out_flags, {24'h0, e[7:0]});
   endtask

   // want < 0: take the reference model; otherwise a hand-derived value
   task automatic step(input logic v, input logic [31:0] g, input logic [31:0] a,
                       input logic [31:0] b, input logic [1:0] rm,
                       input string tag, input int want);
      logic [7:0] f;
      @(negedge clk);
      if (exp_q.size() == 3) compare_head();
      in_valid = v; in_guard = g; in_a = a; in_b = b; in_rmode = rm;
      f = (want < 0) ? ref_flags(a, b, rm) : want[7:0];
      exp_q.push_back({v, v & g[0], f});
      tag_q.push_back(tag);
   endtask

   function automatic logic [31:0] rnd_op(input logic [31:0] base);
      int k;
      logic [7:0]  e;
      logic [22:0] f;
      k = $urandom_range(0, 99);
      f = 23'($urandom);
      if (k < 8) begin e = 8'hff; if (k < 4) f = '0; end
      else if (k < 16) e = 8'h00;
      else if (k < 45) begin
         e = base[30:23] + 8'($urandom_range(0, 4)) - 8'd2;
         if (k < 30) f = base[22:0] ^ 23'($urandom_range(0, 7));
      end
      else if (k < 55) e = 8'hfe - 8'($urandom_range(0, 1));
      else if (k < 65) e = 8'($urandom_range(1, 2));
      else e = 8'($urandom);
      return {1'($urandom), e, f};
   endfunction

   initial begin
      #(200000 * 5);
      if (!done) begin
         failures++;
         $display("FAIL watchdog R9: actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [31:0] a, b;
      // R10: outputs idle during reset
      repeat (3) @(negedge clk);
      check(!out_valid && !out_wr_en, "R10", "idle in reset", {out_valid, out_wr_en}, 0);
      @(negedge clk) rst_n = 1'b1;

      // R2 inexact under nearest-even
      step(1, 1, 32'h7f7fffff, 32'h3f800000, 2'b00, "R2", 8'h02);
      // R3 overflow
      step(1, 1, 32'h7f7fffff, 32'h7f7fffff, 2'b00, "R3", 8'h0a);
      // R4 rounding direction decides overflow
      step(1, 1, 32'h7f7fffff, 32'h3f800000, 2'b10, "R4", 8'h0a);
      step(1, 1, 32'h7f7fffff, 32'h3f800000, 2'b01, "R4", 8'h02);
      step(1, 1, 32'h7f7fffff, 32'h3f800000, 2'b11, "R4", 8'h02);
      step(1, 1, 32'hff7fffff, 32'hbf800000, 2'b11, "R4", 8'h0a);
      step(1, 1, 32'hff7fffff, 32'hbf800000, 2'b10, "R4", 8'h02);
      step(1, 1, 32'h7f7fffff, 32'h7f7fffff, 2'b01, "R3", 8'h0a);
      // R6 tiny result flushed
      step(1, 1, 32'h00a00000, 32'h80800000, 2'b00, "R6", 8'h46);
      // R7 invalid and exact cases
      step(1, 1, 32'h7f800000, 32'hff800000, 2'b00, "R7", 8'h10);
      step(1, 1, 32'h7fc00000, 32'h3f800000, 2'b00, "R7", 8'h10);
      step(1, 1, 32'h7f800000, 32'h3f800000, 2'b00, "R7", 8'h00);
      step(1, 1, 32'h7f800000, 32'h7f800000, 2'b00, "R7", 8'h00);
      step(1, 1, 32'h3f800000, 32'h40000000, 2'b00, "R7", 8'h00);
      step(1, 1, 32'h3f800000, 32'hbf800000, 2'b10, "R7", 8'h00);
      // R5 input flush
      step(1, 1, 32'h40400000, 32'h00400000, 2'b00, "R5", 8'h20);
      step(1, 1, 32'h00400000, 32'h80000001, 2'b00, "R5", 8'h20);
      step(1, 1, 32'h00000001, 32'h7f800000, 2'b00, "R5", 8'h20);
      // R2 ties to even: 1 + 2^-24 stays at 1, inexact
      step(1, 1, 32'h3f800000, 32'h33800000, 2'b00, "R2", 8'h02);
      step(1, 1, 32'h3f800001, 32'h33800000, 2'b00, "R2", -1);
      // R8 guard: only bit 0 matters, flags still reported
      step(1, 32'h0, 32'h7f7fffff, 32'h7f7fffff, 2'b00, "R8", 8'h0a);
      step(1, 32'hfffffffe, 32'h00a00000, 32'h80800000, 2'b00, "R8", 8'h46);
      step(1, 32'h80000001, 32'h3f800000, 32'h3f800000, 2'b00, "R8", 8'h00);
      // R9 bubble pattern
      step(0, 1, 32'h7f7fffff, 32'h7f7fffff, 2'b00, "R9", -1);
      step(1, 1, 32'h7f7fffff, 32'h3f800000, 2'b00, "R9", 8'h02);
      step(0, 1, 32'h0, 32'h0, 2'b00, "R9", -1);

      // Random traffic checked against the reference (R1 R2 R3 R4 R5 R6 R7)
      for (int n = 0; n < 4000; n++) begin
         a = rnd_op(32'h3f800000 ^ 32'($urandom_range(0, 32'h3fffffff)));
         b = rnd_op(a);
         step(($urandom_range(0, 99) < 85) ? 1'b1 : 1'b0, $urandom, a, b,
              2'($urandom_range(0, 3)), "R1", -1);
      end

      // R10: reset mid-stream clears the pipe
      step(1, 1, 32'h3f800000, 32'h3f800000, 2'b00, "R10", -1);
      step(1, 1, 32'h3f800000, 32'h3f800000, 2'b00, "R10", -1);
      @(negedge clk);
      rst_n = 1'b0;
      in_valid = 1'b0;
      #1;
      check(!out_valid && !out_wr_en, "R10", "cleared by reset", {out_valid, out_wr_en}, 0);
      exp_q.delete();
      tag_q.delete();
      @(negedge clk) rst_n = 1'b1;
      for (int n = 0; n < 4; n++) step(0, 1, 32'h0, 32'h0, 2'b00, "R10", -1);
      repeat (3) step(0, 0, 32'h0, 32'h0, 2'b00, "R10", -1);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule